// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Controller

This block watches the transmit and receive FIFOs of a serial controller and turns their fill levels and error events into interrupt status. It keeps its own fill-level counters from the FIFO push and pop strobes. It compares those counters against two programmable thresholds. It also records three error conditions as sticky flags: a push into a full transmit FIFO, a push into a full receive FIFO, and a pop from an empty receive FIFO.

Software reads the state through a small register port. There is a raw status word taken before masking, a masked status word, a mask register, both threshold registers, both fill levels, and an error-clear register that clears the sticky flags when it is read. The single interrupt line is the OR of the masked status bits. Threshold writes that are not below the FIFO depth are dropped. Software can therefore find the depth by writing increasing values and reading each one back. A deasserted enable input empties both counters and clears every sticky flag.

The push and pop strobes are single-cycle events with no back-pressure: each strobe is taken in the cycle it is high, and the full and empty flags from the FIFO decide whether it counts. A register access lasts one cycle. Read data is combinational from the current state, and any side effect of the read lands at the next clock edge.

Top module: `fic_ctrl`

## Requirements
- R1: After reset both fill levels and both thresholds are 0, the mask register reads 0xFF, the masked status reads 0 and `irq` is low.
- R2: While enabled, a push with the full flag low raises that FIFO's level by one and a pop lowers it by one. The pop only counts when the level is non-zero and, for RX, the empty flag is low. A counted push and a counted pop in the same cycle leave the level unchanged. The levels read at address 2 (TX) and 3 (RX).
- R3: A TX push while `tx_full` is high sets the sticky TX-overflow flag (status bit 1) and does not change the TX level.
- R4: An RX pop while `rx_empty` is high sets the sticky RX-underflow flag (bit 2). An RX push while `rx_full` is high sets the sticky RX-overflow flag (bit 3). Neither event changes the RX level.
- R5: A read of address 7 returns the sticky flags in bits 3..1 and clears them at that clock edge. A flag that is set in the same cycle as the clearing read survives it.
- R6: The TX threshold (address 0) and the RX threshold (address 1) accept a write only when the value is below DEPTH. Any other write leaves the stored value unchanged.
- R7: Raw status bit 0 (TX empty) is 1 whenever the TX level is at or below the TX threshold.
- R8: Raw status bit 4 (RX full) is 1 whenever the RX level is strictly greater than the RX threshold.
- R9: Address 5 returns the raw status. Address 6 returns the raw status with every bit cleared whose mask bit (address 4, low byte) is 1. Writing 0xFF to the mask hides every source.
- R10: `irq` is high exactly when some bit of the masked status is 1.
- R11: While `en` is low, both levels are held at 0, all sticky flags are cleared, and strobes neither count nor set flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low clears levels and flags |
| tx_push | input | 1 | TX FIFO write strobe |
| tx_pop | input | 1 | TX FIFO read strobe (serialiser side) |
| tx_full | input | 1 | TX FIFO full flag |
| rx_push | input | 1 | RX FIFO write strobe (serialiser side) |
| rx_pop | input | 1 | RX FIFO read strobe |
| rx_full | input | 1 | RX FIFO full flag |
| rx_empty | input | 1 | RX FIFO empty flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the following:
- The levels stay bounded and an accepted RX push raises the RX level by one.
- Error events set their sticky flags, and a clearing read empties them when no new event coincides.
- An out-of-range threshold write leaves the threshold unchanged.
- The interrupt line agrees with any masked-status read.
- A low enable leaves levels and flags at zero.

Some behaviours depend on a sequence of events and need the bench's scenarios:
- Finding the depth by read-back.
- The exact boundaries of the two threshold comparisons.
- Whether a flag set during a clearing read survives it.
- How each mask pattern maps onto the masked word.

// File: rtl/fic_pkg.sv
`timescale 1ns/1ps
package fic_pkg;
  localparam int NSRC = 5;

  // status bit positions (software decodes these)
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;

  typedef enum logic [2:0] {
    A_TXTHR  = 3'd0,
    A_RXTHR  = 3'd1,
    A_TXLVL  = 3'd2,
    A_RXLVL  = 3'd3,
    A_MASK   = 3'd4,
    A_RAW    = 3'd5,
    A_MSTAT  = 3'd6,
    A_ERRCLR = 3'd7
  } fic_addr_e;
endpackage

// File: rtl/fic_level_ctr.sv
`timescale 1ns/1ps
module fic_level_ctr #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic          pop,
  input  logic          full_i,
  input  logic          empty_i,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  logic inc, dec;
  assign inc = push && !full_i && (level != TOP);
  assign dec = pop && !empty_i && (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (!en)    level <= '0;
    else begin
      case ({inc, dec})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/fic_thr_reg.sv
`timescale 1ns/1ps
module fic_thr_reg #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int TW    = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] thr
);
  logic fits;
  assign fits = (wdata < DW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          thr <= '0;
    else if (wr && fits) thr <= wdata[TW-1:0];
  end
endmodule

// File: rtl/fic_err_flags.sv
`timescale 1ns/1ps
module fic_err_flags
  import fic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tx_ovf_ev,
  input  logic            rx_udf_ev,
  input  logic            rx_ovf_ev,
  input  logic            clr,
  output logic [NSRC-1:0] err
);
  logic [NSRC-1:0] set_v;

  always_comb begin
    set_v        = '0;
    set_v[B_TXO] = tx_ovf_ev;
    set_v[B_RXU] = rx_udf_ev;
    set_v[B_RXO] = rx_ovf_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err <= '0;
    else if (!en) err <= '0;
    else          err <= (clr ? '0 : err) | set_v;
  end
endmodule

// File: rtl/fic_irq_gen.sv
`timescale 1ns/1ps
module fic_irq_gen
  import fic_pkg::*;
#(
  parameter int LW = 5,
  parameter int TW = 4,
  parameter int MW = 8
) (
  input  logic [LW-1:0]   tx_lvl,
  input  logic [LW-1:0]   rx_lvl,
  input  logic [TW-1:0]   tx_thr,
  input  logic [TW-1:0]   rx_thr,
  input  logic [NSRC-1:0] err,
  input  logic [MW-1:0]   mask,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] masked,
  output logic            irq
);
  logic tx_low, rx_high;
  assign tx_low  = ({1'b0, tx_lvl} <= {{(LW + 1 - TW){1'b0}}, tx_thr});
  assign rx_high = ({1'b0, rx_lvl} >  {{(LW + 1 - TW){1'b0}}, rx_thr});

  always_comb begin
    raw        = err;
    raw[B_TXE] = tx_low;
    raw[B_RXF] = rx_high;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign masked[i] = raw[i] & ~mask[i];
  end

  assign irq = |masked;
endmodule

// File: rtl/fic_ctrl.sv
`timescale 1ns/1ps
module fic_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          tx_full,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          rx_full,
  input  logic          rx_empty,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int MW = 8;

  fic_addr_e addr;
  assign addr = fic_addr_e'(reg_addr);

  logic [LW-1:0]   tx_lvl, rx_lvl;
  logic [TW-1:0]   tx_thr, rx_thr;
  logic [NSRC-1:0] err_q, raw, masked;
  logic [MW-1:0]   mask_q;

  fic_level_ctr #(.DEPTH(DEPTH), .LW(LW)) u_txc (
    .clk(clk), .rst_n(rst_n), .en(en), .push(tx_push), .pop(tx_pop),
    .full_i(tx_full), .empty_i(1'b0), .level(tx_lvl));

  fic_level_ctr #(.DEPTH(DEPTH), .LW(LW)) u_rxc (
    .clk(clk), .rst_n(rst_n), .en(en), .push(rx_push), .pop(rx_pop),
    .full_i(rx_full), .empty_i(rx_empty), .level(rx_lvl));

  fic_thr_reg #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_txt (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && addr == A_TXTHR),
    .wdata(reg_wdata), .thr(tx_thr));

  fic_thr_reg #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_rxt (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && addr == A_RXTHR),
    .wdata(reg_wdata), .thr(rx_thr));

  fic_err_flags u_err (
    .clk(clk), .rst_n(rst_n), .en(en),
    .tx_ovf_ev(tx_push && tx_full),
    .rx_udf_ev(rx_pop && rx_empty),
    .rx_ovf_ev(rx_push && rx_full),
    .clr(reg_rd && addr == A_ERRCLR),
    .err(err_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mask_q <= '1;
    else if (reg_wr && addr == A_MASK) mask_q <= reg_wdata[MW-1:0];
  end

  fic_irq_gen #(.LW(LW), .TW(TW), .MW(MW)) u_irq (
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .err(err_q), .mask(mask_q), .raw(raw), .masked(masked), .irq(irq));

  always_comb begin
    reg_rdata = '0;
    case (addr)
      A_TXTHR:  reg_rdata = DW'(tx_thr);
      A_RXTHR:  reg_rdata = DW'(rx_thr);
      A_TXLVL:  reg_rdata = DW'(tx_lvl);
      A_RXLVL:  reg_rdata = DW'(rx_lvl);
      A_MASK:   reg_rdata = DW'(mask_q);
      A_RAW:    reg_rdata = DW'(raw);
      A_MSTAT:  reg_rdata = DW'(masked);
      A_ERRCLR: reg_rdata = DW'(err_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fic_ctrl_chk.sv
`timescale 1ns/1ps
module fic_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int LW    = 5,
  parameter int TW    = 4,
  parameter int NS    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tx_push,
  input logic          tx_full,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          irq,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [TW-1:0] tx_thr,
  input logic [NS-1:0] err_q
);
  logic any_ev;
  assign any_ev = en && ((tx_push && tx_full) || (rx_pop && rx_empty) || (rx_push && rx_full));

  assert_lvl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  assert_rx_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_push && !rx_full && !rx_pop && (rx_lvl < LW'(DEPTH))
    |=> rx_lvl == $past(rx_lvl) + 1'b1);

  assert_tx_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && tx_push && tx_full |=> err_q[1]);

  assert_rx_udf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_pop && rx_empty |=> err_q[2]);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd7 && !any_ev |=> err_q == '0);

  assert_thr_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && (reg_wdata >= DW'(DEPTH)) |=> $stable(tx_thr));

  assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd6 |-> irq == (|reg_rdata));

  assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_lvl == '0 && rx_lvl == '0 && err_q == '0);
endmodule

bind fic_ctrl fic_ctrl_chk #(
  .DEPTH(DEPTH), .DW(DW), .LW(LW), .TW(TW), .NS(fic_pkg::NSRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_push(tx_push), .tx_full(tx_full),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tx_thr(tx_thr), .err_q(err_q)
);

// File: tb/sim_fic_ctrl.sv
`timescale 1ns/1ps
module sim_fic_ctrl;
  localparam int D  = 8;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, en = 0;
  logic tx_push = 0, tx_pop = 0, tx_full = 0;
  logic rx_push = 0, rx_pop = 0, rx_full = 0, rx_empty = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  fic_ctrl #(.DEPTH(D), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_push(tx_push), .tx_pop(tx_pop),
    .tx_full(tx_full), .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .rx_empty(rx_empty), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // monitor: compare each read against the scoreboard at the falling edge
  always @(negedge clk) begin
    if (reg_rd) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %0h expected none", reg_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (reg_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    tx_push = 0; tx_pop = 0; tx_full = 0;
    rx_push = 0; rx_pop = 0; rx_full = 0; rx_empty = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    reg_rd = 1; reg_addr = a;
    tick();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, irq, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (sb.size() != 0) begin
        n_bad++;
        $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset state
    rd(0, 0, "R1 tx thr");
    rd(1, 0, "R1 rx thr");
    rd(2, 0, "R1 tx lvl");
    rd(3, 0, "R1 rx lvl");
    rd(4, 16'hFF, "R1 mask");
    rd(5, 16'h01, "R7 raw after reset");
    rd(6, 0, "R1 masked");
    chk_irq(0, "R1 irq");

    en = 1;
    // R2 TX counting
    for (int i = 0; i < 5; i++) begin tx_push = 1; tick(); end
    rd(2, 5, "R2 tx lvl after 5 pushes");
    rd(5, 16'h00, "R7 5 above thr 0");
    wr(0, 5);
    rd(5, 16'h01, "R7 level equals thr");
    wr(0, 4);
    rd(5, 16'h00, "R7 level above thr");

    // R6 depth discovery
    wr(0, 7);  rd(0, 7, "R6 thr 7 accepted");
    wr(0, 8);  rd(0, 7, "R6 thr 8 ignored");
    wr(0, 200); rd(0, 7, "R6 thr 200 ignored");
    wr(1, 9);  rd(1, 0, "R6 rx thr 9 ignored");

    for (int i = 0; i < 6; i++) begin tx_pop = 1; tick(); end
    rd(2, 0, "R2 tx lvl no wrap");
    rd(5, 16'h01, "R7 empty below thr");

    // R8 RX threshold
    wr(1, 2);
    rx_push = 1; tick();
    rx_push = 1; tick();
    rd(3, 2, "R2 rx lvl 2");
    rd(5, 16'h01, "R8 rx lvl equals thr");
    rx_push = 1; tick();
    rd(5, 16'h11, "R8 rx lvl above thr");
    rx_push = 1; rx_pop = 1; tick();
    rd(3, 3, "R2 push and pop together");
    rx_pop = 1; tick();
    rd(3, 2, "R2 rx pop");
    rd(5, 16'h01, "R8 back at thr");

    // R3 TX overflow and R5 clear-on-read
    tx_push = 1; tx_full = 1; tick();
    rd(2, 0, "R3 tx lvl unchanged");
    rd(5, 16'h03, "R3 raw overflow");
    rd(7, 16'h02, "R5 err read");
    rd(7, 16'h00, "R5 err cleared");

    // R4 RX underflow and overflow
    rx_pop = 1; rx_empty = 1; tick();
    rd(3, 2, "R4 rx lvl after underflow");
    rd(5, 16'h05, "R4 underflow bit");
    rx_push = 1; rx_full = 1; tick();
    rd(3, 2, "R4 rx lvl after overflow");
    rd(5, 16'h0D, "R4 overflow bit");
    rd(7, 16'h0C, "R5 rx err read");
    rd(5, 16'h01, "R5 raw after clear");

    // R9 / R10 mask
    wr(4, 16'h00);
    rd(6, 16'h01, "R9 unmasked");
    chk_irq(1, "R10 irq with tx empty");
    rx_push = 1; tick();
    rd(6, 16'h11, "R9 two sources");
    wr(4, 16'h10); rd(6, 16'h01, "R9 mask rx full");
    wr(4, 16'h01); rd(6, 16'h10, "R9 mask tx empty");
    chk_irq(1, "R10 irq rx full only");
    wr(4, 16'hFF); rd(6, 16'h00, "R9 all masked");
    rd(4, 16'hFF, "R9 mask readback");
    chk_irq(0, "R10 irq all masked");

    // R5 set wins over clear
    tx_push = 1; tx_full = 1; reg_rd = 1; reg_addr = 7;
    begin item_t it; it.exp = 0; it.tag = "R5 clear read during set"; sb.push_back(it); end
    tick();
    rd(5, 16'h13, "R5 flag survives clearing read");
    rd(7, 16'h02, "R5 err after set-wins");

    // R11 disable
    tx_push = 1; tick();
    tx_push = 1; tick();
    rx_pop = 1; rx_empty = 1; tick();
    rd(2, 2, "R2 tx lvl before disable");
    en = 0; tick();
    rd(2, 0, "R11 tx lvl cleared");
    rd(3, 0, "R11 rx lvl cleared");
    rd(7, 0, "R11 flags cleared");
    tx_push = 1; tick();
    tx_push = 1; tx_full = 1; tick();
    rd(2, 0, "R11 push ignored while off");
    rd(5, 16'h01, "R11 no flag while off");
    wr(4, 0);
    chk_irq(1, "R10 irq after unmask");

    tick();
    finish_run();
  end
endmodule